// File: doc/BRIEF.md
# Accumulator Readout Formatter

This block turns a wide multiply-accumulate accumulator into a word that can be written to a general register. The accumulator is a two's-complement value of `ACC_W` bits (48 by default). A 2-bit mode input selects one of three readouts: signed integer, unsigned integer or fractional. The fractional readout takes three more control bits: a half-word select, a rounding enable and a saturation enable. With these it produces either a 32-bit word taken above the low 8 fraction bits, or a 16-bit word taken above the low 24 bits.

Rounding is round-half-to-even, and it is applied before the range check. A carry out of rounding can therefore push a value into saturation. The arithmetic is purely combinational. It feeds a single output register that is loaded only when the input strobe is high, and a valid flag follows the strobe by one cycle. The block sits after the accumulator adder and before the register write-back mux.

Top module: `mac_readout`

## Requirements
- R1: A synchronous active-high reset clears `out_valid_o` and `result_o` to zero on the next clock edge.
- R2: `out_valid_o` equals `in_valid_i` delayed by one clock. `result_o` is loaded only on an edge where `in_valid_i` is high, and it holds its value otherwise.
- R3: In signed-integer mode (`mode_i` = 2'b00), an accumulator that lies within the signed 32-bit range appears unchanged as its low 32 bits.
- R4: In signed-integer mode, an accumulator outside the signed 32-bit range gives 0x7FFFFFFF if its top bit is 0 and 0x80000000 if its top bit is 1.
- R5: In unsigned-integer mode (`mode_i` = 2'b01), the accumulator is read as unsigned. Any set bit at position 32 or above gives 0xFFFFFFFF; otherwise the low 32 bits pass through.
- R6: In fractional mode (`mode_i` = 2'b10) with `half_sel_i`=0 and `round_en_i`=0, the word is the accumulator shifted arithmetically right by 8 bits.
- R7: In fractional mode with `half_sel_i`=0 and `round_en_i`=1, the low 8 bits are a remainder. The shifted value is incremented when the remainder exceeds 0x80. On a remainder of exactly 0x80, it is incremented only if its least significant bit is 1.
- R8: In fractional mode with `half_sel_i`=1, the low 24 bits are a remainder and the bits above them form the value. The value is always rounded half-to-even with the tie at 0x800000, whatever `round_en_i` is.
- R9: In fractional mode with `sat_en_i`=1, a rounded value outside the signed target range (16 or 32 bits) clamps to 0x7FFF/0x7FFFFFFF when positive and to 0x8000/0x80000000 when negative.
- R10: In fractional mode with `sat_en_i`=0, the rounded value is truncated to its low 16 or 32 bits.
- R11: Every 16-bit fractional result is zero-extended, so `result_o[31:16]` is 0.
- R12: Mode 2'b11 behaves exactly as fractional mode 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Strobe: load the formatted accumulator this cycle |
| mode_i | input | 2 | 00 signed int, 01 unsigned int, 10/11 fractional |
| half_sel_i | input | 1 | Fractional: 1 selects the 16-bit word |
| round_en_i | input | 1 | Fractional 32-bit: enable round-half-to-even |
| sat_en_i | input | 1 | Fractional: enable clamping on overflow |
| acc_i | input | ACC_W | Accumulator value, two's complement |
| out_valid_o | output | 1 | Result valid, one cycle after the strobe |
| result_o | output | OUT_W | Formatted result |

## Verification
The assertions assume that the mode and control bits are meaningful only in a cycle where `in_valid_i` is high. They also assume that nothing else stalls the output register, so each property compares the result one cycle after a strobed input against that input's `$past` value. The stimulus drives every input at the falling clock edge and keeps each vector for exactly one strobed cycle. It returns to idle only for the hold checks, and those change the accumulator so that a wrongly enabled register would show. The sweep covers every mode and control combination against accumulators placed exactly at, just below and just above each rounding tie and each range limit, plus pseudo-random fill.

// File: rtl/mac_rd_pkg.sv
package mac_rd_pkg;

    typedef enum logic [1:0] {
        RD_SINT     = 2'b00,
        RD_UINT     = 2'b01,
        RD_FRAC     = 2'b10,
        RD_FRAC_ALT = 2'b11
    } readout_mode_e;

    typedef struct packed {
        logic half_sel;
        logic round_en;
        logic sat_en;
    } frac_ctrl_t;

    function automatic logic is_frac(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/mac_rd_round.sv
// Drops SHIFT low bits from a signed value; optionally rounds half-to-even.
// One extra output bit keeps the carry of rounding.
module mac_rd_round #(
    parameter int IN_W  = 48,
    parameter int SHIFT = 8
) (
    input  logic [IN_W-1:0]    val_i,
    input  logic               rnd_i,
    output logic [IN_W-SHIFT:0] q_o
);
    localparam int QW = IN_W - SHIFT;
    localparam logic [SHIFT-1:0] HALF = {1'b1, {(SHIFT-1){1'b0}}};

    logic [QW-1:0]    q;
    logic [SHIFT-1:0] rem;
    logic             bump;

    always_comb begin
        q    = val_i[IN_W-1:SHIFT];
        rem  = val_i[SHIFT-1:0];
        bump = rnd_i && ((rem > HALF) || ((rem == HALF) && q[0]));
        q_o  = {q[QW-1], q} + {{QW{1'b0}}, bump};
    end
endmodule

// File: rtl/mac_rd_sat.sv
// Narrows a signed value to OUT_W bits: clamp by sign or plain truncation.
module mac_rd_sat #(
    parameter int IN_W  = 41,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  val_i,
    input  logic             sat_i,
    output logic [OUT_W-1:0] res_o
);
    localparam int TOP_W = IN_W - OUT_W + 1;

    logic [TOP_W-1:0] top;
    logic             fits;
    logic [OUT_W-1:0] clamp;

    always_comb begin
        top   = val_i[IN_W-1:OUT_W-1];
        fits  = (&top) || (~|top);
        clamp = val_i[IN_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                              : {1'b0, {(OUT_W-1){1'b1}}};
        res_o = (sat_i && !fits) ? clamp : val_i[OUT_W-1:0];
    end
endmodule

// File: rtl/mac_rd_int.sv
// Integer readouts: signed with clamping, unsigned with all-ones ceiling.
module mac_rd_int #(
    parameter int ACC_W = 48,
    parameter int OUT_W = 32
) (
    input  logic [ACC_W-1:0] acc_i,
    output logic [OUT_W-1:0] sint_o,
    output logic [OUT_W-1:0] uint_o
);
    mac_rd_sat #(.IN_W(ACC_W), .OUT_W(OUT_W)) u_ssat (
        .val_i (acc_i),
        .sat_i (1'b1),
        .res_o (sint_o)
    );

    generate
        if (ACC_W > OUT_W) begin : g_wide
            logic over;
            assign over   = |acc_i[ACC_W-1:OUT_W];
            assign uint_o = over ? {OUT_W{1'b1}} : acc_i[OUT_W-1:0];
        end else begin : g_narrow
            assign uint_o = OUT_W'(acc_i);
        end
    endgenerate
endmodule

// File: rtl/mac_rd_frac.sv
// Fractional readout: 32-bit word above FINE_SH bits, 16-bit above COARSE_SH.
module mac_rd_frac
    import mac_rd_pkg::*;
#(
    parameter int ACC_W     = 48,
    parameter int OUT_W     = 32,
    parameter int HALF_W    = 16,
    parameter int FINE_SH   = 8,
    parameter int COARSE_SH = 24
) (
    input  logic [ACC_W-1:0] acc_i,
    input  frac_ctrl_t       ctl_i,
    output logic [OUT_W-1:0] res_o
);
    localparam int FINE_QW   = ACC_W - FINE_SH + 1;
    localparam int COARSE_QW = ACC_W - COARSE_SH + 1;
    localparam int PAD_W     = OUT_W - HALF_W;

    logic [FINE_QW-1:0]   fine_q;
    logic [COARSE_QW-1:0] coarse_q;
    logic [OUT_W-1:0]     fine_w;
    logic [HALF_W-1:0]    coarse_w;

    mac_rd_round #(.IN_W(ACC_W), .SHIFT(FINE_SH)) u_rnd_fine (
        .val_i (acc_i),
        .rnd_i (ctl_i.round_en),
        .q_o   (fine_q)
    );

    // the half-word readout always rounds
    mac_rd_round #(.IN_W(ACC_W), .SHIFT(COARSE_SH)) u_rnd_coarse (
        .val_i (acc_i),
        .rnd_i (1'b1),
        .q_o   (coarse_q)
    );

    mac_rd_sat #(.IN_W(FINE_QW), .OUT_W(OUT_W)) u_sat_fine (
        .val_i (fine_q),
        .sat_i (ctl_i.sat_en),
        .res_o (fine_w)
    );

    mac_rd_sat #(.IN_W(COARSE_QW), .OUT_W(HALF_W)) u_sat_coarse (
        .val_i (coarse_q),
        .sat_i (ctl_i.sat_en),
        .res_o (coarse_w)
    );

    assign res_o = ctl_i.half_sel ? {{PAD_W{1'b0}}, coarse_w} : fine_w;
endmodule

// File: rtl/mac_readout.sv
module mac_readout
    import mac_rd_pkg::*;
#(
    parameter int ACC_W     = 48,
    parameter int OUT_W     = 32,
    parameter int HALF_W    = 16,
    parameter int FINE_SH   = 8,
    parameter int COARSE_SH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid_i,
    input  logic [1:0]       mode_i,
    input  logic             half_sel_i,
    input  logic             round_en_i,
    input  logic             sat_en_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic             out_valid_o,
    output logic [OUT_W-1:0] result_o
);
    frac_ctrl_t       ctl;
    logic [OUT_W-1:0] sint_res;
    logic [OUT_W-1:0] uint_res;
    logic [OUT_W-1:0] frac_res;
    logic [OUT_W-1:0] next_res;

    assign ctl = '{half_sel: half_sel_i, round_en: round_en_i, sat_en: sat_en_i};

    mac_rd_int #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_int (
        .acc_i  (acc_i),
        .sint_o (sint_res),
        .uint_o (uint_res)
    );

    mac_rd_frac #(
        .ACC_W(ACC_W), .OUT_W(OUT_W), .HALF_W(HALF_W),
        .FINE_SH(FINE_SH), .COARSE_SH(COARSE_SH)
    ) u_frac (
        .acc_i (acc_i),
        .ctl_i (ctl),
        .res_o (frac_res)
    );

    always_comb begin
        if (is_frac(mode_i)) begin
            next_res = frac_res;
        end else if (readout_mode_e'(mode_i) == RD_UINT) begin
            next_res = uint_res;
        end else begin
            next_res = sint_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            result_o    <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                result_o <= next_res;
            end
        end
    end
endmodule

// File: rtl/mac_readout_chk.sv
module mac_readout_chk
    import mac_rd_pkg::*;
#(
    parameter int ACC_W     = 48,
    parameter int OUT_W     = 32,
    parameter int HALF_W    = 16,
    parameter int FINE_SH   = 8,
    parameter int COARSE_SH = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid_i,
    input logic [1:0]       mode_i,
    input logic             half_sel_i,
    input logic             round_en_i,
    input logic             sat_en_i,
    input logic [ACC_W-1:0] acc_i,
    input logic             out_valid_o,
    input logic [OUT_W-1:0] result_o
);
    logic in_srange;
    assign in_srange = (acc_i[ACC_W-1:OUT_W-1] == '0) || (&acc_i[ACC_W-1:OUT_W-1]);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid_o && result_o == '0));

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> out_valid_o);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> (!out_valid_o && $stable(result_o)));

    assert_sint_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && mode_i == RD_SINT && in_srange)
        |=> result_o == $past(acc_i[OUT_W-1:0]));

    assert_uint_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && mode_i == RD_UINT && (|acc_i[ACC_W-1:OUT_W]))
        |=> result_o == {OUT_W{1'b1}});

    assert_frac_shift_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && mode_i[1] && !half_sel_i && !round_en_i && !sat_en_i)
        |=> result_o == $past(acc_i[FINE_SH+OUT_W-1:FINE_SH]));

    assert_half_zero_ext_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && mode_i[1] && half_sel_i)
        |=> result_o[OUT_W-1:HALF_W] == '0);
endmodule

bind mac_readout mac_readout_chk #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .HALF_W(HALF_W),
    .FINE_SH(FINE_SH), .COARSE_SH(COARSE_SH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (in_valid_i),
    .mode_i      (mode_i),
    .half_sel_i  (half_sel_i),
    .round_en_i  (round_en_i),
    .sat_en_i    (sat_en_i),
    .acc_i       (acc_i),
    .out_valid_o (out_valid_o),
    .result_o    (result_o)
);

// File: tb/tb_mac_readout.sv
`timescale 1ns/1ps
module tb_mac_readout;
    localparam int ACC_W = 48;
    localparam int OUT_W = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid_i = 1'b0;
    logic [1:0]       mode_i = 2'b00;
    logic             half_sel_i = 1'b0;
    logic             round_en_i = 1'b0;
    logic             sat_en_i = 1'b0;
    logic [ACC_W-1:0] acc_i = '0;
    logic             out_valid_o;
    logic [OUT_W-1:0] result_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    longint unsigned rng = 64'h9E3779B97F4A7C15;

    always #2 clk = ~clk;

    mac_readout dut (
        .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .mode_i(mode_i),
        .half_sel_i(half_sel_i), .round_en_i(round_en_i), .sat_en_i(sat_en_i),
        .acc_i(acc_i), .out_valid_o(out_valid_o), .result_o(result_o)
    );

    task automatic check(input string req, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h (acc=%012h mode=%0d h=%0b r=%0b s=%0b)",
                     req, act, exp, acc_i, mode_i, half_sel_i, round_en_i, sat_en_i);
        end
    endtask

    // Reference model, written from the requirements in 64-bit arithmetic.
    task automatic model(input logic [ACC_W-1:0] acc, input int m, input int c,
                         output logic [OUT_W-1:0] exp, output string tag);
        longint a, q, rem, half, lo, hi;
        int sh;
        a = longint'({{(64-ACC_W){acc[ACC_W-1]}}, acc});
        if (m == 0) begin
            if (a >= -64'sd2147483648 && a <= 64'sd2147483647) begin
                exp = a[31:0]; tag = "R3";
            end else begin
                exp = acc[ACC_W-1] ? 32'h80000000 : 32'h7FFFFFFF; tag = "R4";
            end
        end else if (m == 1) begin
            exp = (acc[ACC_W-1:32] != 0) ? 32'hFFFFFFFF : acc[31:0]; tag = "R5";
        end else begin
            if (c[2]) begin
                sh = 24; lo = -64'sd32768; hi = 64'sd32767; tag = "R8";
            end else begin
                sh = 8; lo = -64'sd2147483648; hi = 64'sd2147483647;
                tag = c[1] ? "R7" : "R6";
            end
            q    = a >>> sh;
            rem  = a & ((64'sd1 <<< sh) - 1);
            half = 64'sd1 <<< (sh - 1);
            if (c[2] || c[1]) begin
                if (rem > half) q = q + 1;
                else if (rem == half) q = q + (q & 1);
            end
            if (q < lo || q > hi) begin
                if (c[0]) begin
                    tag = "R9";
                    if (c[2]) exp = (q < 0) ? 32'h00008000 : 32'h00007FFF;
                    else      exp = (q < 0) ? 32'h80000000 : 32'h7FFFFFFF;
                end else begin
                    tag = "R10";
                    exp = c[2] ? {16'h0, q[15:0]} : q[31:0];
                end
            end else begin
                exp = c[2] ? {16'h0, q[15:0]} : q[31:0];
                if (c[2]) tag = "R8_R11";
            end
            if (m == 3) tag = {tag, "_R12"};
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic run_vec(input logic [ACC_W-1:0] acc, input int m, input int c);
        logic [OUT_W-1:0] exp;
        string tag;
        in_valid_i = 1'b1;
        acc_i = acc;
        mode_i = m[1:0];
        half_sel_i = c[2];
        round_en_i = c[1];
        sat_en_i = c[0];
        model(acc, m, c, exp, tag);
        @(negedge clk);
        check("R2", {31'b0, out_valid_o}, 32'd1);
        check(tag, result_o, exp);
    endtask

    task automatic sweep(input logic [ACC_W-1:0] acc);
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 8; c++)
                run_vec(acc, m, c);
    endtask

    function automatic logic [ACC_W-1:0] next_rand();
        rng ^= rng << 13;
        rng ^= rng >> 7;
        rng ^= rng << 17;
        return rng[ACC_W-1:0];
    endfunction

    longint fine_base[10] = '{0, 1, 2, 3, -1, -2, -3, 64'sd2147483647, -64'sd2147483648, 64'sd2147483648};
    longint fine_rem[5]   = '{0, 'h7F, 'h80, 'h81, 'hFF};
    longint crs_base[10]  = '{0, 1, 2, -1, -2, 'h7FFF, -'h8000, 'h7FFE, 'h8000, -'h8001};
    longint crs_rem[5]    = '{0, 'h7FFFFF, 'h800000, 'h800001, 'hFFFFFF};
    longint int_edge[9]   = '{64'sd2147483647, 64'sd2147483648, -64'sd2147483648, -64'sd2147483649,
                              64'sd4294967295, 64'sd4294967296, 64'sh7FFFFFFFFFFF,
                              -64'sh800000000000, -1};

    initial begin
        logic [OUT_W-1:0] held;
        repeat (3) @(negedge clk);
        check("R1", {31'b0, out_valid_o}, 32'd0);
        check("R1", result_o, 32'd0);
        rst = 1'b0;

        foreach (int_edge[i]) sweep(int_edge[i][ACC_W-1:0]);
        for (int b = 0; b < 10; b++)
            for (int r = 0; r < 5; r++) begin
                longint v;
                v = (fine_base[b] <<< 8) | fine_rem[r];
                sweep(v[ACC_W-1:0]);
                v = (crs_base[b] <<< 24) | crs_rem[r];
                sweep(v[ACC_W-1:0]);
            end
        for (int k = 0; k < 250; k++) sweep(next_rand());

        // R2: idle cycles leave the result untouched and valid low
        for (int k = 0; k < 8; k++) begin
            held = result_o;
            in_valid_i = 1'b0;
            acc_i = next_rand();
            mode_i = k[1:0];
            @(negedge clk);
            check("R2", {31'b0, out_valid_o}, 32'd0);
            check("R2", result_o, held);
        end

        // R1: reset in mid-run clears a non-zero result
        run_vec(48'h0000_1234_5678, 0, 0);
        rst = 1'b1;
        in_valid_i = 1'b1;
        @(negedge clk);
        check("R1", {31'b0, out_valid_o}, 32'd0);
        check("R1", result_o, 32'd0);
        rst = 1'b0;
        in_valid_i = 1'b0;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule